// File: doc/BRIEF.md
# Multi-mode reloadable down-counter timer

This block is a programmable timer built around a 16-bit compare word and reloadable down-counters. It has three ways of using that word. In baud mode, the low byte divides the clock to make a square wave, and the high byte counts the edges of that wave to mark word boundaries. In PWM mode, the two bytes set the lengths of the high and low phases. In wide mode, all 16 bits act either as a clock divider or as an edge count of an external shift clock.

The counters take a value from the compare input at three points: when the enable rises, and each time a count runs out. A compare change therefore never cuts a count short. While the enable is low, the outputs stay low and the counters keep their values.

A surrounding shifter uses the toggle output as its shift clock and the end-of-word pulse to frame its data.

Top module: `tmr_top`

## Requirements
- R1: While rst_ni is low, and on the first cycle after it is released, tmr_o, shift_clk_o and eow_o are all 0.
- R2: While en_i is low, tmr_o, shift_clk_o and eow_o are 0 in the cycle after each clock edge, and external clock pulses change none of them.
- R3: In baud mode (mode_i = 2'b01), tmr_o starts low at the enable edge. It first toggles cmp_i[7:0]+1 cycles after that edge, and then every cmp_i[7:0]+1 cycles. The full period is therefore (cmp_i[7:0]+1)*2 cycles.
- R4: In baud mode, eow_o pulses high for one cycle on every (cmp_i[15:8]+1)-th toggle of tmr_o, which is (cmp_i[15:8]+1)/2 bits. The pulse comes in the same cycle as that toggle.
- R5: In PWM mode (mode_i = 2'b10), tmr_o goes high at the enable edge and stays high for cmp_i[7:0]+1 cycles. It then stays low for cmp_i[15:8]+1 cycles, and this repeats. eow_o stays 0.
- R6: In wide mode (mode_i = 2'b00 or 2'b11) with ext_src_i = 0, tmr_o toggles every cmp_i[15:0]+1 cycles, counted from the enable edge, and eow_o stays 0.
- R7: In wide mode with ext_src_i = 1, tmr_o toggles once for each cycle in which ext_clk_i is high. It does not change otherwise. eow_o pulses together with every (cmp_i[15:0]+1)-th such toggle.
- R8: A cmp_i change made while the timer is running takes effect only when the affected counter next reloads. The count in progress completes with the old value.
- R9: When en_i is taken low and then high again, a fresh count starts from the current cmp_i. The first toggle falls cmp_i[7:0]+1 cycles after the new enable edge, whatever state the counters were left in.
- R10: shift_clk_o equals tmr_o in baud and wide modes, and is 0 in PWM mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Functional clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Timer enable; its rising edge starts a fresh count |
| mode_i | input | 2 | 00/11 wide, 01 baud, 10 PWM |
| cmp_i | input | 16 | Compare word |
| ext_src_i | input | 1 | Wide mode: 1 counts ext_clk_i pulses, 0 counts clock cycles |
| ext_clk_i | input | 1 | External shift clock pulse, one cycle per edge |
| tmr_o | output | 1 | Timer output level |
| shift_clk_o | output | 1 | Shift clock toggle |
| eow_o | output | 1 | End-of-word pulse |

## Verification
The hardest case to reach from the ports is a compare change landing in the middle of a running count. The check must show that the old value finishes the count and the new value starts with the next reload. The mid-count test writes a new divider three cycles into an eight-cycle half period. It then checks that the toggles fall at cycles 8, 10 and 12.

A restart from a frozen, partly counted state is reached in a similar way. The test disables the timer mid-count, changes the compare word while the timer is idle, and re-enables it. It then checks that the first toggle follows the new value.

Counting of external clock pulses is checked with idle gaps between pulses. This shows that only the pulses advance the count.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef enum logic [1:0] {
    MODE_WIDE     = 2'b00,
    MODE_BAUD     = 2'b01,
    MODE_PWM      = 2'b10,
    MODE_WIDE_ALT = 2'b11
  } tmr_mode_e;
endpackage

// File: rtl/tmr_dn_cnt.sv
module tmr_dn_cnt #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic         dec_i,
  input  logic [W-1:0] val_i,
  output logic [W-1:0] cnt_o,
  output logic         zero_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (load_i) cnt_q <= val_i;
    else if (dec_i)  cnt_q <= cnt_q - 1'b1;
  end

  assign cnt_o  = cnt_q;
  assign zero_o = (cnt_q == '0);

  // never step through zero; reload must own that cycle
  assert_dec_nonzero_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dec_i |-> (!zero_o && !load_i));
endmodule

// File: rtl/tmr_ctrl.sv
module tmr_ctrl
  import tmr_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      en_i,
  input  tmr_mode_e mode_i,
  input  logic      ext_src_i,
  input  logic      ext_clk_i,
  input  logic      lo_zero_i,
  input  logic      hi_zero_i,
  input  logic      wd_zero_i,
  output logic      lo_load_o,
  output logic      lo_dec_o,
  output logic      hi_load_o,
  output logic      hi_dec_o,
  output logic      wd_load_o,
  output logic      wd_dec_o,
  output logic      out_o,
  output logic      eow_o
);
  logic en_q, out_q, eow_q;
  logic start, run, tgl, eow_set, out_d, wd_tick, lo_tick;

  assign start = en_i & ~en_q;
  assign run   = en_i & en_q;

  always_comb begin
    lo_load_o = 1'b0;
    lo_dec_o  = 1'b0;
    hi_load_o = 1'b0;
    hi_dec_o  = 1'b0;
    wd_load_o = 1'b0;
    wd_dec_o  = 1'b0;
    tgl       = 1'b0;
    eow_set   = 1'b0;
    lo_tick   = run & lo_zero_i;
    wd_tick   = run & (ext_src_i ? ext_clk_i : 1'b1);
    case (mode_i)
      MODE_BAUD: begin
        lo_load_o = start | lo_tick;
        lo_dec_o  = run & ~lo_zero_i;
        hi_load_o = start | (lo_tick & hi_zero_i);
        hi_dec_o  = lo_tick & ~hi_zero_i;
        tgl       = lo_tick;
        eow_set   = lo_tick & hi_zero_i;
      end
      MODE_PWM: begin
        // low byte times the high phase, high byte the low phase
        lo_load_o = start | (run & ~out_q & hi_zero_i);
        lo_dec_o  = run & out_q & ~lo_zero_i;
        hi_load_o = run & out_q & lo_zero_i;
        hi_dec_o  = run & ~out_q & ~hi_zero_i;
        tgl       = run & ((out_q & lo_zero_i) | (~out_q & hi_zero_i));
      end
      default: begin
        wd_load_o = start | (wd_tick & wd_zero_i);
        wd_dec_o  = wd_tick & ~wd_zero_i;
        tgl       = ext_src_i ? wd_tick : (wd_tick & wd_zero_i);
        eow_set   = ext_src_i & wd_tick & wd_zero_i;
      end
    endcase
  end

  always_comb begin
    if (start)    out_d = (mode_i == MODE_PWM);
    else if (tgl) out_d = ~out_q;
    else          out_d = out_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q  <= 1'b0;
      out_q <= 1'b0;
      eow_q <= 1'b0;
    end else begin
      en_q <= en_i;
      if (!en_i) begin
        out_q <= 1'b0;
        eow_q <= 1'b0;
      end else begin
        out_q <= out_d;
        eow_q <= eow_set;
      end
    end
  end

  assign out_o = out_q;
  assign eow_o = eow_q;

  assert_off_quiet_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (!out_q && !eow_q));
  assert_pwm_starts_high_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start && mode_i == MODE_PWM) |=> out_q);
  assert_eow_with_toggle_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eow_q |-> (out_q != $past(out_q)));
  assert_wide_timer_no_eow_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !ext_src_i && (mode_i == MODE_WIDE || mode_i == MODE_WIDE_ALT)) |=> !eow_q);
  assert_ext_idle_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run && ext_src_i && !ext_clk_i && (mode_i == MODE_WIDE || mode_i == MODE_WIDE_ALT))
      |=> $stable(out_q));
endmodule

// File: rtl/tmr_top.sv
module tmr_top
  import tmr_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [1:0]       mode_i,
  input  logic [CNT_W-1:0] cmp_i,
  input  logic             ext_src_i,
  input  logic             ext_clk_i,
  output logic             tmr_o,
  output logic             shift_clk_o,
  output logic             eow_o
);
  localparam int HALF_W = CNT_W / 2;

  tmr_mode_e mode;
  logic [1:0] half_load, half_dec, half_zero;
  logic [HALF_W-1:0] half_val [2];
  logic [HALF_W-1:0] half_cnt [2];
  logic wd_load, wd_dec, wd_zero;
  logic [CNT_W-1:0] wd_cnt;
  logic out;

  assign mode = tmr_mode_e'(mode_i);

  // index 0: low byte, index 1: high byte
  for (genvar g = 0; g < 2; g++) begin : g_half
    assign half_val[g] = cmp_i[g*HALF_W +: HALF_W];
    tmr_dn_cnt #(.W(HALF_W)) u_cnt (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .load_i (half_load[g]),
      .dec_i  (half_dec[g]),
      .val_i  (half_val[g]),
      .cnt_o  (half_cnt[g]),
      .zero_o (half_zero[g])
    );
  end

  tmr_dn_cnt #(.W(CNT_W)) u_wide (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (wd_load),
    .dec_i  (wd_dec),
    .val_i  (cmp_i),
    .cnt_o  (wd_cnt),
    .zero_o (wd_zero)
  );

  tmr_ctrl u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (en_i),
    .mode_i    (mode),
    .ext_src_i (ext_src_i),
    .ext_clk_i (ext_clk_i),
    .lo_zero_i (half_zero[0]),
    .hi_zero_i (half_zero[1]),
    .wd_zero_i (wd_zero),
    .lo_load_o (half_load[0]),
    .lo_dec_o  (half_dec[0]),
    .hi_load_o (half_load[1]),
    .hi_dec_o  (half_dec[1]),
    .wd_load_o (wd_load),
    .wd_dec_o  (wd_dec),
    .out_o     (out),
    .eow_o     (eow_o)
  );

  assign tmr_o       = out;
  assign shift_clk_o = out & (mode != MODE_PWM);

  assert_reset_quiet_R1: assert property (@(posedge clk_i)
    !rst_ni |-> (!tmr_o && !eow_o));
  assert_shift_follows_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode != MODE_PWM) |-> (shift_clk_o == tmr_o));
endmodule

// File: tb/tmr_top_test.sv
module tmr_top_test;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic en = 1'b0;
  logic [1:0] mode = 2'b00;
  logic [15:0] cmp = '0;
  logic ext_src = 1'b0;
  logic ext_clk = 1'b0;
  logic tmr, shclk, eow;
  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  tmr_top uut (
    .clk_i(clk), .rst_ni(rst_ni), .en_i(en), .mode_i(mode), .cmp_i(cmp),
    .ext_src_i(ext_src), .ext_clk_i(ext_clk),
    .tmr_o(tmr), .shift_clk_o(shclk), .eow_o(eow)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  task automatic stop_timer();
    @(negedge clk);
    en = 1'b0;
    ext_clk = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  // enable is driven at a negedge; sample k=0 is the negedge after the start edge
  task automatic watch(input string req, input int first, input int period,
                       input int n, input int eow_every, input bit shift_on);
    int k = 0;
    int last = 0;
    int tg = 0;
    int since = 0;
    logic prev = 1'b0;
    en = 1'b1;
    while (tg < n && k < 2000) begin
      @(negedge clk);
      chk({req, " R10 shift"}, int'(shclk), shift_on ? int'(tmr) : 0);
      if (tmr !== prev) begin
        tg++;
        since++;
        chk({req, " toggle cycle"}, k, (tg == 1) ? first : last + period);
        last = k;
        prev = tmr;
        if (eow_every > 0) begin
          chk({req, " eow"}, int'(eow), (since == eow_every) ? 1 : 0);
          if (eow) since = 0;
        end else chk({req, " no eow"}, int'(eow), 0);
      end else if (eow) chk({req, " eow without toggle"}, 1, 0);
      k++;
    end
    chk({req, " toggles seen"}, tg, n);
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    chk("R1 tmr in reset", int'(tmr), 0);
    chk("R1 eow in reset", int'(eow), 0);
    rst_ni = 1'b1;
    @(negedge clk);
    chk("R1 tmr after reset", int'(tmr), 0);
    chk("R1 shift after reset", int'(shclk), 0);
    chk("R1 eow after reset", int'(eow), 0);
  endtask

  task automatic t_baud();
    mode = 2'b01;
    cmp = {8'd3, 8'd2};
    watch("R3 R4 baud", 3, 3, 12, 4, 1'b1);
    stop_timer();
  endtask

  task automatic t_disabled();
    mode = 2'b00;
    ext_src = 1'b1;
    cmp = 16'd0;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      ext_clk = (i % 2 == 0);
      chk("R2 tmr off", int'(tmr), 0);
      chk("R2 shift off", int'(shclk), 0);
      chk("R2 eow off", int'(eow), 0);
    end
    ext_clk = 1'b0;
    ext_src = 1'b0;
  endtask

  task automatic t_pwm();
    int per;
    mode = 2'b10;
    cmp = {8'd4, 8'd2};
    per = 3 + 5;
    en = 1'b1;
    for (int k = 0; k < 32; k++) begin
      @(negedge clk);
      chk("R5 pwm level", int'(tmr), ((k % per) <= 2) ? 1 : 0);
      chk("R5 pwm eow", int'(eow), 0);
      chk("R10 pwm shift", int'(shclk), 0);
    end
    stop_timer();
  endtask

  task automatic t_wide_timer();
    mode = 2'b00;
    ext_src = 1'b0;
    cmp = 16'd5;
    watch("R6 wide", 6, 6, 5, 0, 1'b1);
    stop_timer();
    mode = 2'b11;
    cmp = 16'd1;
    watch("R6 wide alt", 2, 2, 6, 0, 1'b1);
    stop_timer();
  endtask

  task automatic t_wide_ext();
    logic prev;
    mode = 2'b00;
    ext_src = 1'b1;
    cmp = 16'd3;
    en = 1'b1;
    @(negedge clk);
    prev = tmr;
    chk("R7 ext start low", int'(tmr), 0);
    for (int p = 1; p <= 12; p++) begin
      ext_clk = 1'b1;
      @(negedge clk);
      ext_clk = 1'b0;
      chk("R7 ext toggle", int'(tmr != prev), 1);
      chk("R7 ext eow", int'(eow), (p % 4 == 0) ? 1 : 0);
      prev = tmr;
      repeat (2) begin
        @(negedge clk);
        chk("R7 ext idle hold", int'(tmr != prev), 0);
        chk("R7 ext idle eow", int'(eow), 0);
      end
    end
    stop_timer();
    ext_src = 1'b0;
  endtask

  task automatic t_midchange();
    int seen [3];
    int n = 0;
    logic prev = 1'b0;
    mode = 2'b01;
    cmp = {8'd9, 8'd7};
    en = 1'b1;
    for (int k = 0; k < 20 && n < 3; k++) begin
      @(negedge clk);
      if (tmr !== prev) begin
        seen[n] = k;
        n++;
        prev = tmr;
      end
      if (k == 3) cmp = {8'd9, 8'd1};
    end
    chk("R8 toggles seen", n, 3);
    chk("R8 old count completes", seen[0], 8);
    chk("R8 new value second", seen[1], 10);
    chk("R8 new value third", seen[2], 12);
    stop_timer();
  endtask

  task automatic t_restart();
    mode = 2'b01;
    cmp = {8'd1, 8'd4};
    en = 1'b1;
    repeat (3) @(negedge clk);
    en = 1'b0;
    cmp = {8'd1, 8'd2};
    repeat (3) @(negedge clk);
    chk("R9 frozen output low", int'(tmr), 0);
    watch("R9 restart", 3, 3, 4, 2, 1'b1);
    stop_timer();
  endtask

  initial begin
    t_reset();
    t_baud();
    t_disabled();
    t_pwm();
    t_wide_timer();
    t_wide_ext();
    t_midchange();
    t_restart();
    finish_run();
  end

  initial begin
    repeat (100000) @(posedge clk);
    chk("watchdog expired", 1, 0);
    finish_run();
  end
endmodule